// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Indirection

This block is the control sequencer of a small accumulator machine. It steps each instruction through a fetch subcycle, an optional indirect subcycle, an execute subcycle and, when enabled and requested, a hardware interrupt subcycle. It owns the program counter, the instruction register, the memory address register, the memory buffer register and the accumulator. It reaches a single-port synchronous memory with one-cycle read latency through an address, a write-data bus, a read-data bus and separate read and write strobes.

An instruction word is `DATA_W = 4 + ADDR_W` bits wide. Bits `[DATA_W-1:DATA_W-3]` hold the opcode, bit `ADDR_W` is the indirect flag, and bits `[ADDR_W-1:0]` hold the address field. Every memory access takes a request state followed by a capture state. The state is visible on `phase`, and all registers are visible for observation.

Top module: `icseq_top`

## Requirements
- R1: While reset is low, `pc`, `acc` and `int_en` are zero and `phase` is 0 (fetch request).
- R2: In phase 0 the block drives `mem_addr = pc` with `mem_rd` high, and `pc` is one higher on the next cycle. In phase 1 the returned word is captured into both `ir` and `mbr`.
- R3: Phases 2 and 3 (the indirect read) run only when the fetched word has bit `ADDR_W` set. They read the word at the address field, and that word becomes the effective address.
- R4: Opcode 1 (load) reads memory at the effective address and places the word in `acc`.
- R5: Opcode 3 (add) reads memory at the effective address and sets `acc` to the sum modulo 2^DATA_W.
- R6: Opcode 2 (store) writes `acc` to the effective address in phase 4.
- R7: Opcode 4 (jump) loads `pc` with the effective address and makes no memory access in execute. The next phase is 0.
- R8: Opcodes 0, 5, 6 and 7 leave `acc` unchanged, access no memory in execute, and do not redirect the program flow.
- R9: A one-cycle `int_en_set` pulse sets `int_en`. After execute, if `int_en` and `irq_req` are both high, phase 6 clears `int_en`. Phase 7 then writes the current `pc` to `SAVE_ADDR`. The next phase is 0, with `pc = HANDLER_ADDR`.
- R10: With `int_en` low, `irq_req` is ignored and phase 6 never occurs. An interrupt entry does not repeat while the request stays high.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request level |
| int_en_set | input | 1 | Pulse that sets the interrupt-enable bit |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read request; data returns on the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after `mem_rd` |
| phase | output | 3 | Current state code (0..7) |
| pc | output | ADDR_W | Program counter |
| ir | output | DATA_W | Instruction register |
| mar | output | ADDR_W | Memory address register |
| mbr | output | DATA_W | Memory buffer register |
| acc | output | DATA_W | Accumulator |
| int_en | output | 1 | Interrupt-enable bit |

## Verification
Each result is due at a known cycle:

- A fetch takes two cycles and an indirect read adds two more.
- A load or add takes two execute cycles, while a store or jump takes one.
- An interrupt entry adds two cycles after execute.

The bench releases reset on a falling edge and advances whole cycles. It samples `phase`, `pc` and the memory strobes on the falling edge of the exact cycle these counts give. Program-level results are read from the bench memory only after a run long enough for every instruction to retire.

// File: rtl/icseq_pkg.sv
package icseq_pkg;
  localparam int OP_W = 3;

  typedef enum logic [2:0] {
    ST_FREQ  = 3'd0,
    ST_FCAP  = 3'd1,
    ST_IREQ  = 3'd2,
    ST_ICAP  = 3'd3,
    ST_EREQ  = 3'd4,
    ST_ECAP  = 3'd5,
    ST_XSAVE = 3'd6,
    ST_XWR   = 3'd7
  } phase_t;

  localparam logic [OP_W-1:0] OP_LOAD  = 3'd1;
  localparam logic [OP_W-1:0] OP_STORE = 3'd2;
  localparam logic [OP_W-1:0] OP_ADD   = 3'd3;
  localparam logic [OP_W-1:0] OP_JUMP  = 3'd4;

  // opcode needs a second execute cycle to capture read data
  function automatic logic op_reads(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD);
  endfunction

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STORE) || (op == OP_JUMP);
  endfunction
endpackage

// File: rtl/icseq_fsm.sv
module icseq_fsm
  import icseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_ind,
  input  logic [OP_W-1:0] op,
  input  logic            irq_take,
  output phase_t          state
);
  phase_t nxt;
  phase_t after_exec;

  assign after_exec = irq_take ? ST_XSAVE : ST_FREQ;

  always_comb begin
    nxt = state;
    case (state)
      ST_FREQ:  nxt = ST_FCAP;
      ST_FCAP:  nxt = fetch_ind ? ST_IREQ : ST_EREQ;
      ST_IREQ:  nxt = ST_ICAP;
      ST_ICAP:  nxt = ST_EREQ;
      ST_EREQ:  nxt = op_reads(op) ? ST_ECAP : after_exec;
      ST_ECAP:  nxt = after_exec;
      ST_XSAVE: nxt = ST_XWR;
      ST_XWR:   nxt = ST_FREQ;
      default:  nxt = ST_FREQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FREQ;
    else        state <= nxt;
  end

  // R3: indirect read only follows a fetch whose word carried the flag
  a_r3_ind_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IREQ) |-> ($past(state) == ST_FCAP && $past(fetch_ind)));

  // R9: interrupt entry only when taken at the end of execute
  a_r9_entry_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XSAVE) |-> $past(irq_take));

  // R7: jump retires in one execute cycle
  a_r7_jump_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EREQ && op == OP_JUMP) |=> (state == ST_FREQ || state == ST_XSAVE));
endmodule

// File: rtl/icseq_regs.sv
module icseq_regs
  import icseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0FF,
  localparam int DATA_W = OP_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            state,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              irq_req,
  input  logic              int_en_set,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] acc,
  output logic              ie,
  output logic              irq_take,
  output logic [OP_W-1:0]   op,
  output logic [ADDR_W-1:0] ea
);
  function automatic logic [DATA_W-1:0] alu(input logic [OP_W-1:0] o,
                                            input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] d);
    return (o == OP_ADD) ? DATA_W'(a + d) : d;
  endfunction

  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] p);
    return ADDR_W'(p + 1'b1);
  endfunction

  assign op       = ir[DATA_W-1 -: OP_W];
  assign ea       = mbr[ADDR_W-1:0];   // address field or indirect result
  assign irq_take = ie && irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      ir  <= '0;
      mar <= '0;
      mbr <= '0;
      acc <= '0;
      ie  <= 1'b0;
    end else begin
      if (state == ST_XSAVE)  ie <= 1'b0;
      else if (int_en_set)    ie <= 1'b1;
      case (state)
        ST_FREQ: begin
          mar <= pc;
          pc  <= pc_step(pc);
        end
        ST_FCAP: begin
          mbr <= mem_rdata;
          ir  <= mem_rdata;
        end
        ST_IREQ: mar <= ea;
        ST_ICAP: mbr <= mem_rdata;
        ST_EREQ: begin
          if (op_reads(op)) mar <= ea;
          if (op == OP_STORE) begin
            mar <= ea;
            mbr <= acc;
          end
          if (op == OP_JUMP) pc <= ea;
        end
        ST_ECAP: begin
          mbr <= mem_rdata;
          acc <= alu(op, acc, mem_rdata);
        end
        ST_XSAVE: begin
          mbr <= DATA_W'(pc);
          mar <= SAVE_ADDR;
        end
        ST_XWR: pc <= HANDLER_ADDR;
        default: ;
      endcase
    end
  end

  // R2: fetch request advances the program counter by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FREQ) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R9: enable is cleared on entry to the interrupt subcycle
  a_r9_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XSAVE) |=> !ie);

  // R9: handler vector follows the save write
  a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XWR) |=> (pc == HANDLER_ADDR));

  // R8: unknown opcodes leave the accumulator alone
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EREQ && !op_known(op)) |=> $stable(acc));
endmodule

// File: rtl/icseq_memport.sv
module icseq_memport
  import icseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OP_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            state,
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] mar,
  input  logic [DATA_W-1:0] mbr,
  input  logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata
);
  always_comb begin
    mem_addr  = mar;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = mbr;
    case (state)
      ST_FREQ: begin
        mem_addr = pc;
        mem_rd   = 1'b1;
      end
      ST_IREQ: begin
        mem_addr = ea;
        mem_rd   = 1'b1;
      end
      ST_EREQ: begin
        mem_addr = ea;
        if (op_reads(op)) mem_rd = 1'b1;
        if (op == OP_STORE) begin
          mem_wr    = 1'b1;
          mem_wdata = acc;
        end
      end
      ST_XWR: mem_wr = 1'b1;
      default: ;
    endcase
  end

  // R11: never read and write together
  a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R8 / R7: no execute access for jump or unknown opcodes
  a_r8_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EREQ && (!op_known(op) || op == OP_JUMP)) |-> (!mem_rd && !mem_wr));
endmodule

// File: rtl/icseq_top.sv
module icseq_top
  import icseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0FF,
  localparam int DATA_W = OP_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              int_en_set,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [2:0]        phase,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] acc,
  output logic              int_en
);
  phase_t            st;
  logic              irq_take;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] ea;
  logic              fetch_ind;

  assign fetch_ind = mem_rdata[ADDR_W];
  assign phase     = st;

  icseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fetch_ind(fetch_ind), .op(op),
    .irq_take(irq_take), .state(st)
  );

  icseq_regs #(.ADDR_W(ADDR_W), .HANDLER_ADDR(HANDLER_ADDR), .SAVE_ADDR(SAVE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .state(st), .mem_rdata(mem_rdata),
    .irq_req(irq_req), .int_en_set(int_en_set),
    .pc(pc), .ir(ir), .mar(mar), .mbr(mbr), .acc(acc), .ie(int_en),
    .irq_take(irq_take), .op(op), .ea(ea)
  );

  icseq_memport #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .state(st), .op(op), .pc(pc), .ea(ea),
    .mar(mar), .mbr(mbr), .acc(acc),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  // R9: save write lands on the fixed location
  a_r9_save_write: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7) |-> (mem_wr && mem_addr == SAVE_ADDR));
endmodule

// File: tb/icseq_top_tb.sv
module icseq_top_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam logic [AW-1:0] HND = 12'h100;
  localparam logic [AW-1:0] SAV = 12'h0FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 1'b0;
  logic int_en_set = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic [2:0] phase;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, mbr, acc;
  logic int_en;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;

  int checks = 0;
  int failures = 0;
  int excl_bad = 0;
  int xsave_cnt = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  icseq_top #(.ADDR_W(AW), .HANDLER_ADDR(HND), .SAVE_ADDR(SAV)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .int_en_set(int_en_set),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .phase(phase), .pc(pc), .ir(ir), .mar(mar),
    .mbr(mbr), .acc(acc), .int_en(int_en)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
    end
  end

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && mem_rd && mem_wr) excl_bad <= excl_bad + 1;
    if (rst_n && phase == 3'd6) xsave_cnt <= xsave_cnt + 1;
  end

  function automatic logic [DW-1:0] ins(input int op, input bit ind, input int a);
    return {3'(op), ind, 12'(a)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [DW-1:0] d);
    ld_en = 1'b1; ld_addr = 12'(a); ld_data = d;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_req = 1'b0; int_en_set = 1'b0;
    xsave_cnt = 0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    while (cycles < 150000 && !done) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // ---- R1 reset state, R2 fetch timing ----
    hold_reset();
    poke(0, ins(1, 0, 12'h020));
    poke(12'h020, 16'h0777);
    poke(1, ins(4, 0, 1));
    @(negedge clk);
    check("R1 pc", pc, 0);
    check("R1 acc", acc, 0);
    check("R1 ie", int_en, 0);
    check("R1 phase", phase, 0);
    release_reset();
    check("R2 fetch addr", mem_addr, 0);
    check("R2 fetch rd", mem_rd, 1);
    step(1);
    check("R2 phase cap", phase, 1);
    check("R2 pc+1", pc, 1);
    step(1);
    check("R2 ir", ir, ins(1, 0, 12'h020));
    check("R2 exec phase", phase, 4);
    step(2);
    check("R4 load acc", acc, 16'h0777);

    // ---- R3 R4 R5 R6 sweep: values x direct/indirect ----
    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] a, b, sum;
      bit ind;
      ind = i[0];
      a = (i[3:1] == 3'd7) ? 16'hFFFF : 16'(i[3:1] * 16'h2345 + 16'h0011);
      b = (i[3:1] == 3'd7) ? 16'h0001 : 16'(16'hF00F - i[3:1] * 3);
      sum = a + b;
      hold_reset();
      poke(0, ins(1, ind, 12'h040));
      poke(1, ins(3, ind, 12'h041));
      poke(2, ins(2, 0, 12'h042));
      poke(3, ins(4, 0, 3));
      poke(12'h042, 16'hDEAD);
      if (ind) begin
        poke(12'h040, 16'h0050); poke(12'h041, 16'h0051);
        poke(12'h050, a);        poke(12'h051, b);
      end else begin
        poke(12'h040, a); poke(12'h041, b);
      end
      release_reset();
      step(2);
      check(ind ? "R3 indirect phase" : "R3 direct phase", phase, ind ? 2 : 4);
      step(30);
      check("R5 add acc", acc, sum);
      check("R6 store mem", mem[12'h042], sum);
      check("R10 no irq entry", xsave_cnt, 0);
    end

    // ---- R7 jump timing ----
    hold_reset();
    poke(0, ins(4, 0, 12'h00A));
    poke(1, ins(2, 0, 12'h070));
    poke(12'h00A, ins(1, 0, 12'h071));
    poke(12'h00B, ins(2, 0, 12'h072));
    poke(12'h00C, ins(4, 0, 12'h00C));
    poke(12'h070, 16'h1111);
    poke(12'h071, 16'h4242);
    poke(12'h072, 16'h0000);
    release_reset();
    step(2);
    check("R7 no access rd", mem_rd, 0);
    check("R7 no access wr", mem_wr, 0);
    step(1);
    check("R7 pc target", pc, 12'h00A);
    check("R7 phase fetch", phase, 0);
    step(20);
    check("R7 skipped store", mem[12'h070], 16'h1111);
    check("R7 target ran", mem[12'h072], 16'h4242);

    // ---- R8 unknown opcodes ----
    hold_reset();
    poke(0, ins(1, 0, 12'h060));
    poke(1, ins(0, 0, 12'h061));
    poke(2, ins(5, 0, 12'h061));
    poke(3, ins(6, 1, 12'h061));
    poke(4, ins(7, 0, 12'h061));
    poke(5, ins(2, 0, 12'h062));
    poke(6, ins(4, 0, 6));
    poke(12'h060, 16'h0BEE);
    poke(12'h061, 16'h0ABC);
    poke(12'h062, 16'h0000);
    release_reset();
    step(40);
    check("R8 acc kept", acc, 16'h0BEE);
    check("R8 flow kept", mem[12'h062], 16'h0BEE);
    check("R8 no write", mem[12'h061], 16'h0ABC);

    // ---- R10 request ignored while disabled ----
    hold_reset();
    poke(0, ins(1, 0, 12'h020));
    poke(1, ins(2, 0, 12'h021));
    poke(2, ins(4, 0, 2));
    poke(12'h020, 16'h5A5A);
    poke(SAV, 16'hCAFE);
    release_reset();
    irq_req = 1'b1;
    step(30);
    check("R10 ignored count", xsave_cnt, 0);
    check("R10 save untouched", mem[SAV], 16'hCAFE);
    check("R10 program ran", mem[12'h021], 16'h5A5A);

    // ---- R9 interrupt entry ----
    hold_reset();
    poke(0, ins(1, 0, 12'h020));
    poke(12'h020, 16'h1234);
    poke(HND, ins(2, 0, 12'h030));
    poke(HND + 1, ins(4, 0, HND + 1));
    poke(12'h030, 16'h0000);
    poke(SAV, 16'h0000);
    release_reset();
    irq_req = 1'b1;
    int_en_set = 1'b1;
    step(1);
    int_en_set = 1'b0;
    check("R9 ie set", int_en, 1);
    step(3);
    check("R9 save phase", phase, 6);
    step(1);
    check("R9 ie cleared", int_en, 0);
    check("R9 save wr", mem_wr, 1);
    check("R9 save addr", mem_addr, SAV);
    check("R9 save data", mem_wdata, 1);
    step(1);
    check("R9 vector pc", pc, HND);
    check("R9 vector phase", phase, 0);
    step(30);
    check("R9 saved pc", mem[SAV], 1);
    check("R9 handler ran", mem[12'h030], 16'h1234);
    check("R10 single entry", xsave_cnt, 1);
    check("R11 rd/wr exclusive", excl_bad, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule